// File: doc/BRIEF.md
# Prescaled Reset-Bit PWM Generator

This block produces one pulse-width-modulated output from a single 8-bit up-counter. The counter advances once per slow tick, signalled by a one-cycle clock-enable input. A 2-bit prescaler picks which counter bit, when it would become set, clears the counter instead. So the prescaler fixes the period (128, 64, 32 or 16 ticks) and, with it, how many low-order counter bits remain as the live count. The output is high while the live count is below the programmed duty value, so the duty value gives the high time in ticks directly, whatever the prescaler.

Software reaches two byte-wide registers over a plain synchronous bus. Writes are single-cycle strobes and reads are combinational. The control register holds an enable flag and the prescaler. The duty register holds a 7-bit high-time count. Writes to either register act at once. A prescaler change keeps the running count and applies the new clearing bit to it. A duty change is used by the very next compare. When the block is disabled, the counter is held at zero and the output is held low.

Top module: `pwm_resetbit`

## Requirements
- R1: After reset both registers read 0 and `pwm_out` is low.
- R2: Address 0 is the control register: bit 7 is enable and bits [1:0] are the prescaler, while bits [6:2] read 0. Address 1 is the duty register: bits [6:0] hold the duty and bit 7 reads 0.
- R3: The counter advances only on cycles with `tick_en` high. For prescaler p the output period is 128 >> p ticks, which gives exactly 4 rising edges in any window of 4 periods when 0 < duty < period.
- R4: With 0 < duty < period, the output is high for exactly duty ticks of every period, for any prescaler.
- R5: With prescaler 0 and duty 127, the output is high for 127 of every 128 ticks, so it is never constantly high.
- R6: With prescaler ≥ 1 and duty ≥ period (this includes out-of-range duty values), the output stays high continuously and the counter keeps wrapping.
- R7: A duty value of 0 keeps the output low.
- R8: While enable is 0, the counter is held at 0 and the output is low. After re-enabling, counting starts from 0.
- R9: Writing a new prescaler does not clear the counter. The new clearing bit acts on the count already present.
- R10: A new duty value is used by the next compare, within two clock cycles, without waiting for the end of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock enable marking one slow tick |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 1 | Register select: 0 is control, 1 is duty |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bound checker checks the following on every cycle:
- the counter is held when there is no tick;
- the counter wraps to zero at the last count of the period;
- disable forces a zero count and a low output;
- a zero duty keeps the output low;
- a duty at or above the period keeps the output high;
- the unused register bits read as zero.

Some behaviours are only visible over many ticks, so only the bench scenarios show them:
- the exact high-tick count and edge count per period for each prescaler;
- the 127-of-128 limit at prescaler 0;
- the counter surviving a prescaler change;
- the immediate effect of a duty rewrite in mid-period.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;
  localparam int CNT_W  = 8;
  localparam int PS_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 1'b1;

  typedef struct packed {
    logic            en;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/pwmr_rst_sync.sv
module pwmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwmr_regs.sv
module pwmr_regs
  import pwmr_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = PS_W,
  parameter int DTW = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic [PW-1:0]     ps,
  output logic [DTW-1:0]    duty
);
  logic           en_q, en_d;
  logic [PW-1:0]  ps_q, ps_d;
  logic [DTW-1:0] duty_q, duty_d;

  // next-state
  always_comb begin
    en_d   = en_q;
    ps_d   = ps_q;
    duty_d = duty_q;
    if (we && addr == ADDR_CTRL) begin
      en_d = wdata[DW-1];
      ps_d = wdata[PW-1:0];
    end
    if (we && addr == ADDR_DUTY) begin
      duty_d = wdata[DTW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ps_q   <= '0;
      duty_q <= '0;
    end else begin
      en_q   <= en_d;
      ps_q   <= ps_d;
      duty_q <= duty_d;
    end
  end

  // read mux: unused bits return zero
  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[DW-1]   = en_q;
      rdata[PW-1:0] = ps_q;
    end else begin
      rdata[DTW-1:0] = duty_q;
    end
  end

  assign en   = en_q;
  assign ps   = ps_q;
  assign duty = duty_q;
endmodule

// File: rtl/pwmr_counter.sv
module pwmr_counter
  import pwmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [PW-1:0] ps,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] live,
  output logic [CW-1:0] period
);
  localparam int IW = $clog2(CW);

  logic [CW-1:0] cnt_q, cnt_d, inc, mask;
  logic [IW-1:0] clr_idx;

  assign clr_idx = IW'(CW - 1) - IW'(ps);
  assign inc     = cnt_q + CW'(1);

  // bits below the clearing bit form the live count
  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (IW'(i) < clr_idx);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = inc[clr_idx] ? '0 : inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt    = cnt_q;
  assign live   = cnt_q & mask;
  assign period = mask + CW'(1);
endmodule

// File: rtl/pwmr_compare.sv
module pwmr_compare
  import pwmr_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int DTW = CNT_W - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [CW-1:0]  live,
  input  logic [DTW-1:0] duty,
  output logic           pwm
);
  logic pwm_q, pwm_d;

  always_comb begin
    pwm_d = en && (live < CW'(duty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_resetbit.sv
module pwm_resetbit
  import pwmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PS_W,
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              pwm_out
);
  localparam int DTW = CW - 1;

  logic           rst_sync_n;
  ctrl_t          ctrl;
  logic [DTW-1:0] duty;
  logic [CW-1:0]  cnt, live, period;

  pwmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwmr_regs #(.DW(DW), .PW(PW), .DTW(DTW)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .en    (ctrl.en),
    .ps    (ctrl.ps),
    .duty  (duty)
  );

  pwmr_counter #(.CW(CW), .PW(PW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_en),
    .en     (ctrl.en),
    .ps     (ctrl.ps),
    .cnt    (cnt),
    .live   (live),
    .period (period)
  );

  pwmr_compare #(.CW(CW), .DTW(DTW)) u_cmp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ctrl.en),
    .live  (live),
    .duty  (duty),
    .pwm   (pwm_out)
  );
endmodule

// File: rtl/pwmr_checker.sv
module pwmr_checker
  import pwmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int PW = PS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              en,
  input logic [CW-2:0]     duty,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     period,
  input logic              pwm_out,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata
);
  // R8
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  // R8
  dis_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick_en |=> $stable(cnt));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick_en && cnt == period - CW'(1) |=> cnt == '0);

  // R6
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && CW'(duty) >= period |=> pwm_out);

  // R7
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty == '0 |=> !pwm_out);

  // R2
  rd_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_CTRL |-> bus_rdata[DW-2:PW] == '0);

  // R2
  rd_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_DUTY |-> !bus_rdata[DW-1]);
endmodule

bind pwm_resetbit pwmr_checker #(.CW(CW), .DW(DW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_en   (tick_en),
  .en        (ctrl.en),
  .duty      (duty),
  .cnt       (cnt),
  .period    (period),
  .pwm_out   (pwm_out),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_pwm_resetbit.sv
module sim_pwm_resetbit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {prescaler[1:0], duty[7:0], high ticks per period[7:0], rises per 4 periods[3:0]}
  localparam bit [21:0] VEC [NVEC] = '{
    {2'd0, 8'd0,   8'd0,   4'd0},
    {2'd0, 8'd1,   8'd1,   4'd4},
    {2'd0, 8'd64,  8'd64,  4'd4},
    {2'd0, 8'd127, 8'd127, 4'd4},
    {2'd1, 8'd32,  8'd32,  4'd4},
    {2'd1, 8'd64,  8'd64,  4'd0},
    {2'd2, 8'd5,   8'd5,   4'd4},
    {2'd2, 8'd31,  8'd31,  4'd4},
    {2'd3, 8'd15,  8'd15,  4'd4},
    {2'd3, 8'd16,  8'd16,  4'd0},
    {2'd3, 8'd100, 8'd16,  4'd0},
    {2'd1, 8'd0,   8'd0,   4'd0}
  };

  logic       clk, rst_n, tick_en, bus_we, bus_addr, pwm_out;
  logic [7:0] bus_wdata, bus_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwm_resetbit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    tick_en = 0;
    forever begin
      @(negedge clk);
      tick_en = ~tick_en;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // wait for one tick edge, then sample the output after its register stage
  task automatic tick_sample(output logic s);
    @(posedge clk);
    while (!tick_en) @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    s = pwm_out;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic s;
    int hi, rises, per;
    logic prev;
    bit seen;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(1'b0, r); check(r == 8'h00, "R1 ctrl", r, 0);
    rd(1'b1, r); check(r == 8'h00, "R1 duty", r, 0);
    check(pwm_out == 1'b0, "R1 pwm", pwm_out, 0);

    // R2 readback with unused bits masked
    wr(1'b0, 8'hFF); rd(1'b0, r); check(r == 8'h83, "R2 ctrl", r, 8'h83);
    wr(1'b1, 8'hFF); rd(1'b1, r); check(r == 8'h7F, "R2 duty", r, 8'h7F);
    wr(1'b0, 8'h00);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] p;
      logic [7:0] d, h;
      logic [3:0] er;
      string tag;
      {p, d, h, er} = VEC[i];
      per = 128 >> p;
      wr(1'b0, 8'h00);
      wr(1'b1, d);
      wr(1'b0, {1'b1, 5'b0, p});
      for (int k = 0; k < per; k++) tick_sample(s);
      prev = s; hi = 0; rises = 0;
      for (int k = 0; k < 4 * per; k++) begin
        tick_sample(s);
        if (s) hi++;
        if (s && !prev) rises++;
        prev = s;
      end
      if (d == 0) tag = "R7";
      else if (d >= per) tag = "R6";
      else if (p == 0 && d == 127) tag = "R5";
      else tag = "R4";
      check(hi == 4 * int'(h), tag, hi, 4 * int'(h));
      check(rises == int'(er), "R3 rises", rises, er);
    end

    // R8 disable holds low and clears counter
    wr(1'b0, 8'h00); wr(1'b1, 8'd50); wr(1'b0, 8'h80);
    for (int k = 0; k < 70; k++) tick_sample(s);
    wr(1'b0, 8'h00);
    hi = 0;
    for (int k = 0; k < 128; k++) begin tick_sample(s); if (s) hi++; end
    check(hi == 0, "R8 low while disabled", hi, 0);
    wr(1'b0, 8'h80);
    tick_sample(s);
    check(s == 1'b1, "R8 restart from zero", s, 1);

    // R9 prescaler change keeps the count
    wr(1'b0, 8'h00); wr(1'b1, 8'd127); wr(1'b0, 8'h80);
    for (int k = 0; k < 40; k++) tick_sample(s);
    wr(1'b1, 8'd8); wr(1'b0, 8'h83);
    tick_sample(s); tick_sample(s);
    check(s == 1'b0, "R9 count kept", s, 0);
    seen = 0;
    for (int k = 0; k < 10; k++) begin tick_sample(s); if (s) seen = 1; end
    check(seen == 1'b1, "R9 wraps later", seen, 1);

    // R10 duty takes effect immediately
    wr(1'b0, 8'h00); wr(1'b1, 8'd0); wr(1'b0, 8'h80);
    for (int k = 0; k < 10; k++) tick_sample(s);
    check(s == 1'b0, "R10 low before", s, 0);
    wr(1'b1, 8'd100);
    @(posedge clk); @(negedge clk);
    check(pwm_out == 1'b1, "R10 raise at once", pwm_out, 1);
    wr(1'b1, 8'd5);
    @(posedge clk); @(negedge clk);
    check(pwm_out == 1'b0, "R10 drop at once", pwm_out, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule